// File: doc/BRIEF.md
# Bus Cycle Sequencer with Hold Release and Dual Ready

This block sequences cycles on a processor bus where every bus state lasts two phases. A phase-enable input advances the phase, and each state ends after its second phase. A requested cycle runs a command state (TS) and then one or more wait states (TC). It ends at the end of a wait state when a ready condition is present. Ready can come from two places. The asynchronous ready input passes through a synchronizer and is then captured for the rest of the cycle. The synchronous ready input counts only at the end of the second phase of a wait state.

An external master requests the bus with `hold_req`. The block finishes the cycle in progress, refuses to release the bus while a locked sequence is running, and then enters the hold state and raises `hold_ack`. The bus signals fall into two groups that stop being driven at different times. Group A carries address, memory/IO and code/acknowledge; it is released in the second phase of the last state before hold. Group B carries byte-high enable and lock; it is released in the first phase of the first hold state. Status stays at its inactive-high value for the whole time the bus is held. When `hold_req` drops, the bus passes through an idle state before any new command state.

Top module: `busrel_ctl`

## Requirements
- R1: Reset puts the block in idle. In reset state `bus_st`=0 (idle), `grp_a_oe`=1, `grp_b_oe`=1, `hold_ack`=0, `stat_n`=2'b11 and `lock_out`=0. `bus_st` encodes idle=0, command=1, wait=2, hold=3. `bus_ph` is 0 in the first phase of a state and 1 in the second. Each `ph_en` pulse advances the phase. A command state is always followed by a wait state.
- R2: When the block ends idle or a final wait state with `req_valid` high and no hold taken, it enters the command state and pulses `req_take` in that state's first phase. During the command state `stat_n` is 2'b10 for a write and 2'b01 for a read. At all other times `stat_n` is 2'b11.
- R3: Synchronous ready is sampled at the end of the second phase of each wait state. If no ready is present, another wait state follows. A cycle with ready first present in its k-th wait state has exactly k wait states.
- R4: Asynchronous ready passes through a two-flop synchronizer. Once seen during a command or wait state, it is held, and the cycle ends at the next wait-state end even if the input has already dropped.
- R5: `end_by_async` is updated with each `cyc_done` pulse. It is 1 if asynchronous ready ended the cycle, in which case synchronous ready is ignored even when both are present. It is 0 when synchronous ready alone ended the cycle.
- R6: `hold_req` is sampled at the end of the first phase of a state. If it is raised in the first phase of an idle state, `hold_ack` rises after 2 phase advances. If it is raised in the second phase, `hold_ack` rises after 3.
- R7: A cycle in progress when `hold_req` rises completes with `cyc_done` before `hold_ack` rises.
- R8: `grp_a_oe` falls only at the start of a second phase (the second phase of the last idle or wait state before hold).
- R9: `grp_b_oe` falls together with the rise of `hold_ack`, in the first phase of the first hold state. Both enables stay 0 while `hold_ack` is 1.
- R10: While `hold_ack` is 1, `stat_n` is 2'b11 and no request is taken.
- R11: `req_lock` taken with a request sets `lock_out` for that cycle. A locked cycle followed by a waiting request chains straight into the next cycle. While `lock_out` is 1, hold is not granted and group A stays driven.
- R12: When `hold_req` drops, `hold_ack` falls in the same cycle that the block enters idle with both enables at 1. A hold state is never followed directly by a command state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ph_en | input | 1 | Phase advance pulse |
| req_valid | input | 1 | Cycle request pending |
| req_write | input | 1 | Requested cycle is a write |
| req_lock | input | 1 | Requested cycle is part of a locked sequence |
| rdy_async | input | 1 | Asynchronous ready, unsynchronized |
| rdy_sync | input | 1 | Synchronous ready |
| hold_req | input | 1 | External master requests the bus |
| req_take | output | 1 | One-clock pulse when a request enters the command state |
| cyc_done | output | 1 | One-clock pulse when a cycle ends |
| end_by_async | output | 1 | Last cycle ended by asynchronous ready |
| stat_n | output | 2 | Active-low cycle status |
| lock_out | output | 1 | Locked sequence in progress |
| grp_a_oe | output | 1 | Drive enable, address / memory-IO / code-acknowledge group |
| grp_b_oe | output | 1 | Drive enable, byte-high / lock group |
| hold_ack | output | 1 | Bus granted to the external master |
| bus_st | output | 2 | Current bus state |
| bus_ph | output | 1 | Current phase within the state |

## Verification
The assertions check on every cycle the rules that relate outputs at a single edge: inactive status and both enables released during hold, no grant while locked, group B released only together with the hold grant and in a first phase, group A released only at a second phase, and no command state straight after hold. The scenarios show the behaviours that depend on sequence and count: the number of wait states for a given ready timing, the held asynchronous ready outliving its pulse, the source reported when both readies are present, the 2- or 3-phase grant delay set by the phase in which hold arrives, a cycle completing before the grant, and a locked pair of cycles delaying the grant.

// File: rtl/busrel_pkg.sv
package busrel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_WAIT = 2'd2,
    ST_HOLD = 2'd3
  } bstate_t;

  localparam int STAT_W = 2;
  localparam logic [STAT_W-1:0] STAT_RD  = 2'b01;
  localparam logic [STAT_W-1:0] STAT_WR  = 2'b10;
  localparam logic [STAT_W-1:0] STAT_OFF = 2'b11;
endpackage

// File: rtl/busrel_sync.sv
module busrel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/busrel_ready.sv
module busrel_ready
  import busrel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    rdy_async,
  input  logic    rdy_sync,
  input  bstate_t st,
  input  logic    tick2,
  output logic    rdy_ok,
  output logic    by_async
);
  logic a_sync;
  logic a_hit;
  logic in_cyc;
  logic end_now;

  busrel_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rdy_async),
    .q   (a_sync)
  );

  always_comb begin
    in_cyc   = (st == ST_CMD) || (st == ST_WAIT);
    by_async = a_hit || a_sync;
    rdy_ok   = by_async || rdy_sync;
    end_now  = tick2 && (st == ST_WAIT) && rdy_ok;
  end

  // captured asynchronous ready lives until the cycle ends
  always_ff @(posedge clk) begin
    if (rst)                  a_hit <= 1'b0;
    else if (end_now)         a_hit <= 1'b0;
    else if (in_cyc && a_sync) a_hit <= 1'b1;
  end
endmodule

// File: rtl/busrel_fsm.sv
module busrel_fsm
  import busrel_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    ph_en,
  input  logic    hold_req,
  input  logic    req_valid,
  input  logic    req_lock,
  input  logic    rdy_ok,
  output bstate_t st,
  output bstate_t nxt,
  output logic    ph,
  output logic    tick1,
  output logic    tick2,
  output logic    rel_now,
  output logic    lock_q,
  output logic    cyc_end
);
  logic hold_seen;

  always_comb begin
    tick1   = ph_en & ~ph;
    tick2   = ph_en & ph;
    rel_now = hold_req & ~lock_q;
    cyc_end = tick2 && (st == ST_WAIT) && rdy_ok;
  end

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE: begin
        if (hold_seen && !lock_q) nxt = ST_HOLD;
        else if (req_valid)       nxt = ST_CMD;
        else                      nxt = ST_IDLE;
      end
      ST_CMD:  nxt = ST_WAIT;
      ST_WAIT: begin
        if (!rdy_ok)                  nxt = ST_WAIT;
        else if (lock_q && req_valid) nxt = ST_CMD;
        else if (hold_seen && !lock_q) nxt = ST_HOLD;
        else if (req_valid)           nxt = ST_CMD;
        else                          nxt = ST_IDLE;
      end
      ST_HOLD: nxt = hold_seen ? ST_HOLD : ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ph        <= 1'b0;
      hold_seen <= 1'b0;
      lock_q    <= 1'b0;
    end else begin
      if (ph_en) ph <= ~ph;
      if (tick1) hold_seen <= hold_req;
      if (tick2) begin
        st <= nxt;
        if (nxt == ST_CMD)
          lock_q <= req_lock;
        else if (nxt == ST_IDLE || nxt == ST_HOLD)
          lock_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/busrel_drive.sv
module busrel_drive
  import busrel_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  bstate_t           st,
  input  bstate_t           nxt,
  input  logic              tick1,
  input  logic              tick2,
  input  logic              rel_now,
  input  logic              req_write,
  input  logic              by_async,
  input  logic              cyc_end,
  output logic              grp_a_oe,
  output logic              grp_b_oe,
  output logic              hold_ack,
  output logic [STAT_W-1:0] stat_n,
  output logic              req_take,
  output logic              cyc_done,
  output logic              end_by_async
);
  always_ff @(posedge clk) begin
    if (rst) begin
      grp_a_oe     <= 1'b1;
      grp_b_oe     <= 1'b1;
      hold_ack     <= 1'b0;
      stat_n       <= STAT_OFF;
      req_take     <= 1'b0;
      cyc_done     <= 1'b0;
      end_by_async <= 1'b0;
    end else begin
      req_take <= tick2 && (nxt == ST_CMD);
      cyc_done <= cyc_end;
      if (cyc_end) end_by_async <= by_async;
      // group A lets go in the second phase of the state before hold
      if (tick1 && (st == ST_IDLE || st == ST_WAIT))
        grp_a_oe <= ~rel_now;
      if (tick2) begin
        if (nxt == ST_HOLD)      grp_a_oe <= 1'b0;
        else if (nxt != ST_WAIT) grp_a_oe <= 1'b1;
        grp_b_oe <= (nxt != ST_HOLD);
        hold_ack <= (nxt == ST_HOLD);
        stat_n   <= (nxt == ST_CMD) ? (req_write ? STAT_WR : STAT_RD) : STAT_OFF;
      end
    end
  end
endmodule

// File: rtl/busrel_ctl.sv
module busrel_ctl
  import busrel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ph_en,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic       req_lock,
  input  logic       rdy_async,
  input  logic       rdy_sync,
  input  logic       hold_req,
  output logic       req_take,
  output logic       cyc_done,
  output logic       end_by_async,
  output logic [1:0] stat_n,
  output logic       lock_out,
  output logic       grp_a_oe,
  output logic       grp_b_oe,
  output logic       hold_ack,
  output logic [1:0] bus_st,
  output logic       bus_ph
);
  bstate_t st, nxt;
  logic ph, tick1, tick2, rel_now, lock_q, cyc_end, rdy_ok, by_async;

  busrel_ready #(.SYNC_STAGES(SYNC_STAGES)) u_ready (
    .clk       (clk),
    .rst       (rst),
    .rdy_async (rdy_async),
    .rdy_sync  (rdy_sync),
    .st        (st),
    .tick2     (tick2),
    .rdy_ok    (rdy_ok),
    .by_async  (by_async)
  );

  busrel_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .ph_en     (ph_en),
    .hold_req  (hold_req),
    .req_valid (req_valid),
    .req_lock  (req_lock),
    .rdy_ok    (rdy_ok),
    .st        (st),
    .nxt       (nxt),
    .ph        (ph),
    .tick1     (tick1),
    .tick2     (tick2),
    .rel_now   (rel_now),
    .lock_q    (lock_q),
    .cyc_end   (cyc_end)
  );

  busrel_drive u_drive (
    .clk          (clk),
    .rst          (rst),
    .st           (st),
    .nxt          (nxt),
    .tick1        (tick1),
    .tick2        (tick2),
    .rel_now      (rel_now),
    .req_write    (req_write),
    .by_async     (by_async),
    .cyc_end      (cyc_end),
    .grp_a_oe     (grp_a_oe),
    .grp_b_oe     (grp_b_oe),
    .hold_ack     (hold_ack),
    .stat_n       (stat_n),
    .req_take     (req_take),
    .cyc_done     (cyc_done),
    .end_by_async (end_by_async)
  );

  assign bus_st   = st;
  assign bus_ph   = ph;
  assign lock_out = lock_q;
endmodule

// File: rtl/busrel_ctl_chk.sv
module busrel_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_take,
  input logic [1:0] stat_n,
  input logic       lock_out,
  input logic       grp_a_oe,
  input logic       grp_b_oe,
  input logic       hold_ack,
  input logic [1:0] bus_st,
  input logic       bus_ph
);
  // R1
  cmd_then_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_st == 2'd1) |=> (bus_st == 2'd1 || bus_st == 2'd2));

  // R2
  stat_only_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_n != 2'b11) |-> (bus_st == 2'd1));

  // R2
  take_in_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    req_take |-> (bus_st == 2'd1 && !bus_ph));

  // R8
  a_float_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(grp_a_oe) |-> bus_ph);

  // R9
  b_float_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(grp_b_oe) |-> (bus_st == 2'd3 && !bus_ph && hold_ack));

  // R9
  hold_float_chk: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> (!grp_a_oe && !grp_b_oe));

  // R10
  hold_stat_chk: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> (stat_n == 2'b11 && !req_take));

  // R11
  lock_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
    lock_out |-> (!hold_ack && grp_a_oe));

  // R12
  hold_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_st == 2'd3) |=> (bus_st != 2'd1));
endmodule

bind busrel_ctl busrel_ctl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_take (req_take),
  .stat_n   (stat_n),
  .lock_out (lock_out),
  .grp_a_oe (grp_a_oe),
  .grp_b_oe (grp_b_oe),
  .hold_ack (hold_ack),
  .bus_st   (bus_st),
  .bus_ph   (bus_ph)
);

// File: tb/busrel_ctl_test.sv
`timescale 1ns/1ps
module busrel_ctl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ph_en = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_lock = 1'b0;
  logic rdy_async = 1'b0, rdy_sync = 1'b0, hold_req = 1'b0;
  logic req_take, cyc_done, end_by_async, lock_out, grp_a_oe, grp_b_oe, hold_ack, bus_ph;
  logic [1:0] stat_n, bus_st;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  always @(posedge clk) ph_en <= rst ? 1'b0 : ~ph_en;

  busrel_ctl uut (
    .clk(clk), .rst(rst), .ph_en(ph_en), .req_valid(req_valid), .req_write(req_write),
    .req_lock(req_lock), .rdy_async(rdy_async), .rdy_sync(rdy_sync), .hold_req(hold_req),
    .req_take(req_take), .cyc_done(cyc_done), .end_by_async(end_by_async), .stat_n(stat_n),
    .lock_out(lock_out), .grp_a_oe(grp_a_oe), .grp_b_oe(grp_b_oe), .hold_ack(hold_ack),
    .bus_st(bus_st), .bus_ph(bus_ph)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // edge monitor on enables, grant and state order
  logic p_a = 1'b1, p_b = 1'b1, p_ack = 1'b0;
  logic [1:0] p_st = 2'd0;
  always @(negedge clk) begin
    if (!rst) begin
      if (p_a && !grp_a_oe) chk(bus_ph == 1'b1, "R8 group A release phase", bus_ph, 1);
      if (p_b && !grp_b_oe) chk(bus_st == 2'd3 && !bus_ph && hold_ack,
                                "R9 group B release in hold phase 1", {bus_st, bus_ph}, 6);
      if (p_ack && !hold_ack) chk(bus_st == 2'd0 && grp_a_oe && grp_b_oe,
                                  "R12 bus driven on hold exit", {bus_st, grp_a_oe, grp_b_oe}, 3);
      if (p_st == 2'd3 && bus_st != 2'd3) chk(bus_st != 2'd1, "R12 no command after hold", bus_st, 0);
    end
    p_a = grp_a_oe; p_b = grp_b_oe; p_ack = hold_ack; p_st = bus_st;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic start_req(input bit wr);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr;
    do @(negedge clk); while (!req_take);
    req_valid = 1'b0;
  endtask

  // runs after req_take to cycle end, counting wait states
  task automatic run_cycle(input int sync_at, input bit apulse, output int tcs);
    logic lp;
    tcs = 0;
    lp = bus_ph;
    do begin
      @(negedge clk);
      if (bus_st == 2'd2 && !bus_ph && lp) begin
        tcs++;
        if (tcs == sync_at) rdy_sync = 1'b1;
        if (apulse && tcs == 1) begin
          rdy_async = 1'b1;
          @(negedge clk);
          rdy_async = 1'b0;
        end
      end
      lp = bus_ph;
    end while (!cyc_done);
  endtask

  task automatic t_reset();
    chk(bus_st == 2'd0 && !bus_ph, "R1 reset state", bus_st, 0);
    chk(grp_a_oe && grp_b_oe && !hold_ack && !lock_out, "R1 reset enables",
        {grp_a_oe, grp_b_oe, hold_ack, lock_out}, 12);
    chk(stat_n == 2'b11, "R1 reset status", stat_n, 3);
  endtask

  task automatic t_sync_plain();
    int n;
    rdy_sync = 1'b1;
    start_req(1'b0);
    chk(bus_st == 2'd1 && stat_n == 2'b01, "R2 read status in command", stat_n, 1);
    run_cycle(0, 1'b0, n);
    chk(n == 1, "R3 zero-wait cycle", n, 1);
    chk(end_by_async == 1'b0, "R5 sync-only end source", end_by_async, 0);
    chk(bus_st == 2'd0 && stat_n == 2'b11, "R2 idle after cycle", stat_n, 3);
    start_req(1'b1);
    chk(stat_n == 2'b10, "R2 write status in command", stat_n, 2);
    run_cycle(0, 1'b0, n);
    chk(n == 1, "R1 command followed by wait", n, 1);
  endtask

  task automatic t_waits();
    int n;
    rdy_sync = 1'b0;
    start_req(1'b0);
    run_cycle(3, 1'b0, n);
    chk(n == 3, "R3 wait count", n, 3);
  endtask

  task automatic t_async_held();
    int n;
    rdy_sync = 1'b0;
    start_req(1'b0);
    run_cycle(0, 1'b1, n);
    chk(n == 1, "R4 held async ends first wait", n, 1);
    chk(end_by_async == 1'b1, "R5 async end source", end_by_async, 1);
  endtask

  task automatic t_both();
    int n;
    rdy_sync = 1'b1; rdy_async = 1'b1;
    start_req(1'b0);
    run_cycle(0, 1'b0, n);
    chk(end_by_async == 1'b1, "R5 sync ignored after async", end_by_async, 1);
    rdy_async = 1'b0;
    repeat (6) @(negedge clk);
    start_req(1'b0);
    run_cycle(0, 1'b0, n);
    chk(end_by_async == 1'b0, "R5 source back to sync", end_by_async, 0);
  endtask

  task automatic grant_delay(input bit in_ph2, output int n);
    logic lp;
    do @(negedge clk); while (!(bus_st == 2'd0 && bus_ph == in_ph2));
    hold_req = 1'b1;
    lp = bus_ph; n = 0;
    while (!hold_ack) begin
      @(negedge clk);
      if (bus_ph != lp) begin n++; lp = bus_ph; end
    end
  endtask

  task automatic t_hold_idle();
    int n;
    bit bad;
    rdy_sync = 1'b1;
    grant_delay(1'b0, n);
    chk(n == 2, "R6 grant delay phase 1", n, 2);
    req_valid = 1'b1;
    bad = 1'b0;
    repeat (12) begin
      @(negedge clk);
      if (bus_st != 2'd3 || stat_n != 2'b11 || req_take || grp_a_oe || grp_b_oe) bad = 1'b1;
    end
    chk(!bad, "R10 hold keeps status high and request waiting", bad, 0);
    hold_req = 1'b0;
    do @(negedge clk); while (!req_take);
    req_valid = 1'b0;
    run_cycle(0, 1'b0, n);
    chk(n == 1, "R12 pending request served after hold", n, 1);
    grant_delay(1'b1, n);
    chk(n == 3, "R6 grant delay phase 2", n, 3);
    hold_req = 1'b0;
    do @(negedge clk); while (hold_ack);
  endtask

  task automatic t_hold_cycle();
    bit done_first, a_low_tc;
    int tcs;
    logic lp;
    rdy_sync = 1'b0;
    start_req(1'b0);
    do @(negedge clk); while (bus_st != 2'd2);
    hold_req = 1'b1;
    done_first = 1'b0; a_low_tc = 1'b0; tcs = 1; lp = bus_ph;
    while (!hold_ack) begin
      @(negedge clk);
      if (cyc_done) done_first = 1'b1;
      if (bus_st == 2'd2 && !grp_a_oe) a_low_tc = 1'b1;
      if (bus_st == 2'd2 && !bus_ph && lp) begin tcs++; if (tcs == 2) rdy_sync = 1'b1; end
      lp = bus_ph;
    end
    chk(done_first, "R7 cycle done before grant", done_first, 1);
    chk(a_low_tc, "R8 group A released in final wait", a_low_tc, 1);
    hold_req = 1'b0;
    do @(negedge clk); while (hold_ack);
  endtask

  task automatic t_lock();
    int dones, takes;
    bit lock_seen, bad;
    rdy_sync = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_lock = 1'b1;
    do @(negedge clk); while (!req_take);
    hold_req = 1'b1;
    dones = 0; takes = 1; lock_seen = 1'b0; bad = 1'b0;
    while (!hold_ack) begin
      @(negedge clk);
      if (cyc_done) dones++;
      if (req_take) begin
        takes++;
        lock_seen = lock_out;
        req_valid = 1'b0; req_lock = 1'b0;
      end
      if (lock_out && (hold_ack || !grp_a_oe)) bad = 1'b1;
    end
    chk(lock_seen, "R11 lock chained to second cycle", lock_seen, 1);
    chk(dones == 2, "R11 grant waits for locked pair", dones, 2);
    chk(!bad, "R11 no grant or release under lock", bad, 0);
    hold_req = 1'b0;
    do @(negedge clk); while (hold_ack);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sync_plain();
    t_waits();
    t_async_held();
    t_both();
    t_hold_idle();
    t_hold_cycle();
    t_lock();
    repeat (8) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule